// File: doc/BRIEF.md
# Effective Address Sequencer for an 8-bit CPU

This unit works out the 16-bit effective address of an operand for an 8-bit processor. It covers zero-page indexed, PC-relative, pre-indexed indirect and post-indexed indirect addressing. A one-cycle `start` pulse carries a mode code, the two index registers and the program counter, which points at the operand byte. The unit latches all of these. It then fetches the operand byte through a byte-wide read port with one cycle of latency. For the indirect modes it also fetches the two pointer bytes from page zero. When the address is ready, the unit raises `done` for one cycle.

The immediate mode fetches its operand byte but produces no address. The byte is presented on `operand` instead. The implied mode, which also stands for the accumulator form and for the spare code, fetches nothing and finishes at once. `pcOut` returns the program counter as it stands after the operand fetch.

Mode codes on `mode`: 0 implied/accumulator, 1 immediate, 2 zero-page+X, 3 zero-page+Y, 4 relative, 5 (zp,X), 6 (zp),Y, 7 treated as implied.

Top module: `ea_gen`

## Requirements
- R1: While `rstN` is low and in the first cycle after its release, `done`, `memRd` and `addrValid` are 0.
- R2: In modes 2 and 3, `effAddr` is {0x00, (operand + index) mod 256}, using X for mode 2 and Y for mode 3. The result never leaves page zero.
- R3: In mode 4, the operand byte is signed, so 0x80..0xFF means minus (256 − byte). `effAddr` = (pcIn + 1 + offset) mod 65536.
- R4: In mode 5, the pointer low byte is read from page-zero address (operand + X) mod 256 and the high byte from (operand + X + 1) mod 256. `effAddr` is {high, low}.
- R5: In mode 6, the pointer low byte is read from page-zero address operand and the high byte from (operand + 1) mod 256. `effAddr` = ({high, low} + Y) mod 65536.
- R6: With `done`, `pcOut` equals pcIn + 1 in every mode that fetches an operand byte, and equals pcIn in the implied mode.
- R7: With `done`, `addrValid` is 1 for modes 2 to 6 and 0 for modes 0, 1 and 7. In mode 1, `operand` holds the byte read from pcIn.
- R8: `done` is high for exactly one cycle. Counting the cycle in which `start` is sampled as cycle 0, `done` arrives in cycle 1 for implied modes, cycle 3 for modes 1 to 4, and cycle 6 for modes 5 and 6.
- R9: `start` is ignored from the cycle after it is accepted through the `done` cycle. Changes to `mode`, `idxX`, `idxY` and `pcIn` in that window do not alter the result. A `start` in the cycle after `done` is accepted.
- R10: `memRd` is high for one cycle per byte read: 0 reads for implied, 1 for modes 1 to 4, 3 for modes 5 and 6. `memData` is taken in the cycle after the read, and pointer reads address page zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a sequence (sampled when idle) |
| mode | input | 3 | Addressing mode code |
| idxX | input | 8 | X index register |
| idxY | input | 8 | Y index register |
| pcIn | input | 16 | Address of the operand byte |
| memRd | output | 1 | Read strobe |
| memAddr | output | 16 | Read address |
| memData | input | 8 | Read data, valid one cycle after memRd |
| done | output | 1 | One-cycle completion pulse |
| addrValid | output | 1 | effAddr is meaningful for this mode |
| effAddr | output | 16 | Effective address |
| operand | output | 8 | Fetched operand byte |
| pcOut | output | 16 | Program counter after the operand fetch |

## Verification
Zero-page indexing is tried with sums below 0x100 and with sums that carry out of the byte. This separates a correct 8-bit wrap from a leak into page one. Relative branches use a small forward offset, the offset 0x80 from 0x0002 and a forward offset from 0xFFFE, so a wrong sign extension or a missing 16-bit wrap shows up. Indirect modes are run with pointers inside page zero and with zp = 0xFF or zp + X = 0xFF, so the pointer high byte must wrap to 0x00. They are also run with a (zp),Y sum that overflows 16 bits. Further runs hold `start` high with changed inputs through a whole sequence, and issue starts back to back, to show that latched values are kept and that no extra sequence begins.

// File: rtl/ea_pkg.sv
package ea_pkg;
  typedef enum logic [2:0] {
    MD_IMP = 3'd0,
    MD_IMM = 3'd1,
    MD_ZPX = 3'd2,
    MD_ZPY = 3'd3,
    MD_REL = 3'd4,
    MD_IZX = 3'd5,
    MD_IZY = 3'd6,
    MD_RSV = 3'd7
  } eaMode_e;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic load;     // latch mode inputs
    logic issueOp;  // read operand at pc, bump pc
    logic capOp;    // capture operand byte
    logic issueLo;  // read pointer low byte
    logic issueHi;  // read pointer high byte
    logic capLo;    // capture pointer low byte
    logic capHi;    // capture pointer high byte
  } eaStrb_t;
endpackage

// File: rtl/ea_ctrl.sv
module ea_ctrl
  import ea_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  logic [2:0] modeIn,
  output eaStrb_t strb,
  output eaMode_e curMode,
  output logic    memRd,
  output logic    done,
  output logic    busy
);
  typedef enum logic [2:0] {
    S_IDLE, S_OPISS, S_OPWAIT, S_LOISS, S_HIISS, S_HIWAIT, S_DONE
  } seqSt_e;

  seqSt_e stQ, stD;
  eaMode_e newMode;

  assign newMode = eaMode_e'(modeIn);

  function automatic logic fetchesOp(input eaMode_e m);
    return (m != MD_IMP) && (m != MD_RSV);
  endfunction

  function automatic logic isIndirect(input eaMode_e m);
    return (m == MD_IZX) || (m == MD_IZY);
  endfunction

  always_comb begin
    stD = stQ;
    unique case (stQ)
      S_IDLE:   if (start) stD = fetchesOp(newMode) ? S_OPISS : S_DONE;
      S_OPISS:  stD = S_OPWAIT;
      S_OPWAIT: stD = isIndirect(curMode) ? S_LOISS : S_DONE;
      S_LOISS:  stD = S_HIISS;
      S_HIISS:  stD = S_HIWAIT;
      S_HIWAIT: stD = S_DONE;
      S_DONE:   stD = S_IDLE;
      default:  stD = S_IDLE;
    endcase
  end

  always_comb begin
    strb         = '0;
    strb.load    = (stQ == S_IDLE) && start;
    strb.issueOp = (stQ == S_OPISS);
    strb.capOp   = (stQ == S_OPWAIT);
    strb.issueLo = (stQ == S_LOISS);
    strb.issueHi = (stQ == S_HIISS);
    strb.capLo   = (stQ == S_HIISS);
    strb.capHi   = (stQ == S_HIWAIT);
  end

  assign memRd = strb.issueOp | strb.issueLo | strb.issueHi;
  assign done  = (stQ == S_DONE);
  assign busy  = (stQ != S_IDLE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stQ     <= S_IDLE;
      curMode <= MD_IMP;
    end else begin
      stQ <= stD;
      if (strb.load) curMode <= newMode;
    end
  end
endmodule

// File: rtl/ea_dpath.sv
module ea_dpath
  import ea_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int ADDR_W = 2 * DATA_W,
  localparam int PAD_W  = ADDR_W - DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  eaStrb_t           strb,
  input  eaMode_e           curMode,
  input  logic [DATA_W-1:0] idxX,
  input  logic [DATA_W-1:0] idxY,
  input  logic [ADDR_W-1:0] pcIn,
  input  logic [DATA_W-1:0] memData,
  output logic [ADDR_W-1:0] memAddr,
  output logic              addrValid,
  output logic [ADDR_W-1:0] effAddr,
  output logic [DATA_W-1:0] operand,
  output logic [ADDR_W-1:0] pcOut
);
  logic [ADDR_W-1:0] pcQ;
  logic [DATA_W-1:0] xQ, yQ, opQ, loQ, hiQ;
  logic [DATA_W-1:0] ptrBase, ptrNext, zpSum;
  logic [ADDR_W-1:0] relOff, ptrWord;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pcQ <= '0;
      xQ  <= '0;
      yQ  <= '0;
      opQ <= '0;
      loQ <= '0;
      hiQ <= '0;
    end else begin
      if (strb.load) begin
        pcQ <= pcIn;
        xQ  <= idxX;
        yQ  <= idxY;
      end else if (strb.issueOp) begin
        pcQ <= pcQ + ADDR_W'(1);
      end
      if (strb.capOp) opQ <= memData;
      if (strb.capLo) loQ <= memData;
      if (strb.capHi) hiQ <= memData;
    end
  end

  // page-zero arithmetic wraps at the byte width
  assign ptrBase = (curMode == MD_IZX) ? opQ + xQ : opQ;
  assign ptrNext = ptrBase + DATA_W'(1);
  assign zpSum   = opQ + ((curMode == MD_ZPY) ? yQ : xQ);
  assign relOff  = {{PAD_W{opQ[DATA_W-1]}}, opQ};
  assign ptrWord = {hiQ, loQ};

  always_comb begin
    memAddr = '0;
    if (strb.issueOp)      memAddr = pcQ;
    else if (strb.issueLo) memAddr = {{PAD_W{1'b0}}, ptrBase};
    else if (strb.issueHi) memAddr = {{PAD_W{1'b0}}, ptrNext};
  end

  always_comb begin
    effAddr   = '0;
    addrValid = 1'b1;
    unique case (curMode)
      MD_ZPX, MD_ZPY: effAddr = {{PAD_W{1'b0}}, zpSum};
      MD_REL:         effAddr = pcQ + relOff;
      MD_IZX:         effAddr = ptrWord;
      MD_IZY:         effAddr = ptrWord + {{PAD_W{1'b0}}, yQ};
      default:        addrValid = 1'b0;
    endcase
  end

  assign operand = opQ;
  assign pcOut   = pcQ;
endmodule

// File: rtl/ea_gen.sv
module ea_gen
  import ea_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int ADDR_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [2:0]        mode,
  input  logic [DATA_W-1:0] idxX,
  input  logic [DATA_W-1:0] idxY,
  input  logic [ADDR_W-1:0] pcIn,
  output logic              memRd,
  output logic [ADDR_W-1:0] memAddr,
  input  logic [DATA_W-1:0] memData,
  output logic              done,
  output logic              addrValid,
  output logic [ADDR_W-1:0] effAddr,
  output logic [DATA_W-1:0] operand,
  output logic [ADDR_W-1:0] pcOut
);
  eaStrb_t ctrlStrb;
  eaMode_e curMode;
  logic    busy;

  ea_ctrl ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .modeIn  (mode),
    .strb    (ctrlStrb),
    .curMode (curMode),
    .memRd   (memRd),
    .done    (done),
    .busy    (busy)
  );

  ea_dpath #(.DATA_W(DATA_W)) dpath_i (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (ctrlStrb),
    .curMode   (curMode),
    .idxX      (idxX),
    .idxY      (idxY),
    .pcIn      (pcIn),
    .memData   (memData),
    .memAddr   (memAddr),
    .addrValid (addrValid),
    .effAddr   (effAddr),
    .operand   (operand),
    .pcOut     (pcOut)
  );
endmodule

// File: rtl/ea_gen_chk.sv
module ea_gen_chk
  import ea_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int ADDR_W = 2 * DATA_W
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              done,
  input logic              memRd,
  input logic [ADDR_W-1:0] memAddr,
  input logic              addrValid,
  input logic [ADDR_W-1:0] effAddr,
  input logic [ADDR_W-1:0] pcOut,
  input eaMode_e           curMode,
  input eaStrb_t           ctrlStrb,
  input logic              busy
);
  localparam int PAD_W = ADDR_W - DATA_W;

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R8

  AST_NO_READ_AT_DONE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !memRd); // R10

  AST_PTR_IN_PAGE0: assert property (@(posedge clk) disable iff (!rstN)
    (memRd && !ctrlStrb.issueOp) |-> (memAddr[ADDR_W-1:DATA_W] == PAD_W'(0))); // R4

  AST_ZP_RESULT: assert property (@(posedge clk) disable iff (!rstN)
    (done && (curMode == MD_ZPX || curMode == MD_ZPY)) |->
      (addrValid && effAddr[ADDR_W-1:DATA_W] == PAD_W'(0))); // R2

  AST_NO_ADDR_MODES: assert property (@(posedge clk) disable iff (!rstN)
    (done && (curMode == MD_IMP || curMode == MD_IMM || curMode == MD_RSV)) |-> !addrValid); // R7

  AST_PC_STEP: assert property (@(posedge clk) disable iff (!rstN)
    ctrlStrb.issueOp |=> (pcOut == $past(pcOut) + ADDR_W'(1))); // R6

  AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start) |=> $stable(curMode)); // R9
endmodule

bind ea_gen ea_gen_chk #(.DATA_W(DATA_W)) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .start     (start),
  .done      (done),
  .memRd     (memRd),
  .memAddr   (memAddr),
  .addrValid (addrValid),
  .effAddr   (effAddr),
  .pcOut     (pcOut),
  .curMode   (curMode),
  .ctrlStrb  (ctrlStrb),
  .busy      (busy)
);

// File: tb/ea_gen_tb_top.sv
`timescale 1ns/1ps
module ea_gen_tb_top;
  import ea_pkg::*;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rstN, start, memRd, done, addrValid;
  logic [2:0]  mode;
  logic [7:0]  idxX, idxY, memData, operand;
  logic [15:0] pcIn, memAddr, effAddr, pcOut;

  ea_gen dut_i (
    .clk(clk), .rstN(rstN), .start(start), .mode(mode), .idxX(idxX), .idxY(idxY),
    .pcIn(pcIn), .memRd(memRd), .memAddr(memAddr), .memData(memData), .done(done),
    .addrValid(addrValid), .effAddr(effAddr), .operand(operand), .pcOut(pcOut)
  );

  logic [7:0] zpMem [256];
  logic [7:0] hiMem [256];

  function automatic logic [7:0] memAt(input logic [15:0] a);
    return (a[15:8] == 8'h00) ? zpMem[a[7:0]] : hiMem[a[7:0]];
  endfunction

  initial memData = 8'h00;
  always @(posedge clk) if (memRd) memData <= memAt(memAddr);

  int cycCnt = 0;
  always @(posedge clk) cycCnt <= cycCnt + 1;

  int checks = 0, bad = 0, spur = 0, rdCnt = 0;

  typedef struct {
    logic [15:0] addr;
    logic        vld;
    logic [15:0] pc;
    logic [7:0]  opb;
    logic        chkOp;
    int          cyc;
    int          reads;
    string       tag;
  } expItem_t;

  expItem_t expQ[$];

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // monitor: compare each completion with the oldest expectation
  expItem_t e;
  always @(negedge clk) begin
    if (rstN && done) begin
      if (expQ.size() == 0) begin
        spur++;
        bad++;
        $display("FAIL R9 spurious done actual=1 expected=0");
      end else begin
        e = expQ.pop_front();
        check(e.tag, "effAddr", {16'h0, addrValid ? effAddr : 16'h0}, {16'h0, e.addr});
        check("R7", "addrValid", {31'h0, addrValid}, {31'h0, e.vld});
        check("R6", "pcOut", {16'h0, pcOut}, {16'h0, e.pc});
        if (e.chkOp) check("R7", "operand", {24'h0, operand}, {24'h0, e.opb});
        check("R8", "latency", cycCnt, e.cyc);
        check("R10", "reads", rdCnt, e.reads);
      end
      rdCnt = 0;
    end else if (rstN && memRd) begin
      rdCnt++;
    end
  end

  // driver: predicts the result, pushes it, runs the sequence
  task automatic runOp(input logic [2:0] md, input logic [15:0] pc, input logic [7:0] x,
                       input logic [7:0] y, input logic hold, input string tag);
    expItem_t   it;
    logic [7:0] opb, base, basePlus;
    logic [15:0] nextPc, ptr;
    int lat;
    @(negedge clk);
    opb = memAt(pc);
    nextPc = pc + 16'd1;
    it.addr = 16'h0; it.vld = 1'b1; it.pc = nextPc; it.opb = opb; it.chkOp = 1'b0;
    it.reads = 1; lat = 3; it.tag = tag;
    case (md)
      3'd1: begin it.vld = 1'b0; it.chkOp = 1'b1; end
      3'd2: begin base = opb + x; it.addr = {8'h00, base}; end
      3'd3: begin base = opb + y; it.addr = {8'h00, base}; end
      3'd4: it.addr = nextPc + {{8{opb[7]}}, opb};
      3'd5, 3'd6: begin
        base = (md == 3'd5) ? opb + x : opb;
        basePlus = base + 8'd1;
        ptr = {memAt({8'h00, basePlus}), memAt({8'h00, base})};
        it.addr = (md == 3'd6) ? ptr + {8'h00, y} : ptr;
        it.reads = 3; lat = 6;
      end
      default: begin it.vld = 1'b0; it.pc = pc; it.reads = 0; lat = 1; end
    endcase
    it.cyc = cycCnt + lat;
    expQ.push_back(it);
    mode = md; pcIn = pc; idxX = x; idxY = y; start = 1'b1;
    @(negedge clk);
    if (hold) begin
      mode = 3'd0; pcIn = 16'hBEEF; idxX = ~x; idxY = ~y;
    end else begin
      start = 1'b0;
    end
    while (!done) @(negedge clk);
    if (hold) begin
      @(negedge clk);
      start = 1'b0;
    end
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin
      zpMem[i] = 8'h00;
      hiMem[i] = 8'h00;
    end
    rstN = 1'b0; start = 1'b0; mode = 3'd0; idxX = 8'h0; idxY = 8'h0; pcIn = 16'h0;
    repeat (3) @(negedge clk);
    check("R1", "done in reset", {31'h0, done}, 32'h0);
    check("R1", "memRd in reset", {31'h0, memRd}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", "done after reset", {31'h0, done}, 32'h0);
    check("R1", "memRd after reset", {31'h0, memRd}, 32'h0);
    check("R1", "addrValid after reset", {31'h0, addrValid}, 32'h0);

    // R2 zero-page indexed, plain and wrapping
    hiMem[8'h34] = 8'h10; runOp(3'd2, 16'h1234, 8'h05, 8'h77, 1'b0, "R2");
    hiMem[8'h50] = 8'hF0; runOp(3'd2, 16'h2250, 8'h20, 8'h00, 1'b0, "R2");
    hiMem[8'h51] = 8'h80; runOp(3'd3, 16'h2251, 8'h33, 8'h90, 1'b0, "R2");
    // R3 relative: forward, 0x80 from 0x0002, wrap past 0xFFFF
    hiMem[8'h00] = 8'h10; runOp(3'd4, 16'h3000, 8'h00, 8'h00, 1'b0, "R3");
    zpMem[8'h02] = 8'h80; runOp(3'd4, 16'h0002, 8'h00, 8'h00, 1'b0, "R3");
    hiMem[8'hFE] = 8'h7F; runOp(3'd4, 16'hFFFE, 8'h00, 8'h00, 1'b0, "R3");
    // R4 pre-indexed indirect, plain and zp+X wrap
    hiMem[8'h60] = 8'h20; zpMem[8'h24] = 8'h34; zpMem[8'h25] = 8'h12;
    runOp(3'd5, 16'h4060, 8'h04, 8'h00, 1'b0, "R4");
    hiMem[8'h61] = 8'hFF; zpMem[8'h00] = 8'hCD; zpMem[8'h01] = 8'hAB;
    runOp(3'd5, 16'h4061, 8'h01, 8'h00, 1'b0, "R4");
    hiMem[8'h62] = 8'hFE; zpMem[8'hFF] = 8'h78;
    runOp(3'd5, 16'h4062, 8'h01, 8'h00, 1'b0, "R4");
    // R5 post-indexed indirect: carry into high byte, pointer wrap, 16-bit wrap
    hiMem[8'h70] = 8'h40; zpMem[8'h40] = 8'hF0; zpMem[8'h41] = 8'h12;
    runOp(3'd6, 16'h5070, 8'h00, 8'h20, 1'b0, "R5");
    hiMem[8'h71] = 8'hFF; zpMem[8'hFF] = 8'hF0; zpMem[8'h00] = 8'hFF;
    runOp(3'd6, 16'h5071, 8'h00, 8'h20, 1'b0, "R5");
    // R7 no-address modes
    hiMem[8'h80] = 8'h5A; runOp(3'd1, 16'h5080, 8'h00, 8'h00, 1'b0, "R7");
    runOp(3'd0, 16'h6000, 8'h00, 8'h00, 1'b0, "R7");
    runOp(3'd7, 16'h6010, 8'h00, 8'h00, 1'b0, "R7");
    // R9 start held high with changed inputs through busy and done cycles
    runOp(3'd5, 16'h4060, 8'h04, 8'h00, 1'b1, "R9");
    runOp(3'd2, 16'h1234, 8'h05, 8'h77, 1'b1, "R9");
    runOp(3'd0, 16'h6100, 8'h00, 8'h00, 1'b1, "R9");
    runOp(3'd6, 16'h5070, 8'h00, 8'h20, 1'b0, "R9");

    repeat (10) @(negedge clk);
    check("R9", "spurious done count", spur, 0);
    check("R8", "outstanding expectations", expQ.size(), 0);
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    bad++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule